// File: doc/BRIEF.md
# Scatter-Gather DMA Channel Register and Interrupt-Merging Block

This block holds the software-visible control and status registers for one scatter-gather DMA channel and decides when that channel raises its interrupt. Software reaches it through a 32-bit register port with single-cycle write and read strobes. The transfer engine sees the block through a few signals. It sends a one-cycle pulse for each finished packet and a pulse when it runs out of work. It receives a start pulse, a tail-updated pulse and the two descriptor pointers.

Interrupts are merged in two ways. A completion counter is loaded from a programmable threshold and raises a completion flag when it runs down. A delay timer is restarted by each completion and raises a delay flag if no further completion comes before it expires. A prescaler of `TICK_DIV` clock cycles paces the timer. The live counter and timer values can be read back through the status register. A soft-reset control bit returns the channel to its halted state. That bit stays set until software next reads the control register.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, control reads 0x0001_0002 (threshold 1, tail-pointer mode) and status reads 0x0001_0001 (halted set, live count 1, timer 0, no flags).
- R2: Registers sit at byte offsets 0x00 control, 0x04 status, 0x08 current descriptor and 0x10 tail descriptor. Control bit 1 always reads 1, whatever was written.
- R3: Writing control with bit 2 set performs a soft reset. Control becomes threshold 1 with tail mode, status becomes halted only, the count becomes 1 and the timer stops. Every control write while bit 2 is pending repeats the soft reset and ignores the run bit. A control read returns the value with bit 2 clear and clears the pending bit.
- R4: A control write outside soft reset stores the value with bit 1 forced and reloads the count from bits 23:16. If bit 0 (run) is set, the write also clears halted and idle, and start_o pulses for exactly one cycle after the write cycle.
- R5: Each done_pulse decrements the count. A pulse that finds the count at 1 sets status bit 12 and reloads the threshold. A count of 0 wraps to 255.
- R6: A done_pulse with control bits 31:24 non-zero loads the timer with that value. The running timer steps down once every TICK_DIV cycles. When it steps from 1 to 0, status bit 13 is set and the count reloads from the threshold.
- R7: Writing 1 to status bits 14:12 clears those flags. Status writes leave halted, idle and the other flags unchanged.
- R8: irq is high exactly when a status flag in bits 14:12 is set and the control bit at the same position is also set.
- R9: A status read returns the timer in bits 31:24, the count in bits 23:16, the flags in 14:12, idle in bit 1 and halted in bit 0. All other bits read 0.
- R10: A tail-descriptor write stores the value on tail_desc_o and clears idle. tail_kick_o pulses for one cycle after the write cycle.
- R11: An idle_set pulse sets status bit 1.
- R12: The current-descriptor register is written and read at 0x08 and drives cur_desc_o. Reads at unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle reg_rd is high |
| done_pulse | input | 1 | One-cycle packet-completion pulse from the engine |
| idle_set | input | 1 | Engine reports it has run out of descriptors |
| irq | output | 1 | Level interrupt |
| start_o | output | 1 | One-cycle pulse when run is set |
| tail_kick_o | output | 1 | One-cycle pulse after a tail-descriptor write |
| run_o | output | 1 | Current run/stop control bit |
| cur_desc_o | output | 32 | Current descriptor pointer |
| tail_desc_o | output | 32 | Tail descriptor pointer |

## Verification
The bench runs a threshold of three and confirms that the completion flag appears on the third pulse and not on the second. An off-by-one counter would flag one pulse early or one pulse late. It lets the delay timer run out untouched and compares the live timer field on every read. A prescaler that miscounts, or an expiry that fails to reload the count, shows up as a wrong status word. It also issues writes while a soft reset is still pending, so a design that cleared the reset bit at once, or accepted the run bit, would emit a start pulse or report the channel as not halted. It sets a zero threshold to check that the count wraps. It writes status with the halted and idle bit positions set to show that only the flag bits respond.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W   = 6,
  parameter int TICK_DIV = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              done_pulse,
  input  logic              idle_set,
  output logic              irq,
  output logic              start_o,
  output logic              tail_kick_o,
  output logic              run_o,
  output logic [31:0]       cur_desc_o,
  output logic [31:0]       tail_desc_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_TAIL = ADDR_W'(16);
  localparam logic [31:0] CTRL_INIT = 32'h0001_0002;
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [31:0]      ctrl_q, cur_q, tail_q;
  logic             halt_q, idle_q;
  logic [2:0]       flag_q;
  logic [7:0]       cnt_q, tmr_q, cnt_d;
  logic [PRE_W-1:0] pre_q;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire wr_cur   = reg_wr && reg_addr == A_CUR;
  wire wr_tail  = reg_wr && reg_addr == A_TAIL;
  wire rd_ctrl  = reg_rd && !reg_wr && reg_addr == A_CTRL;
  wire soft_rst = wr_ctrl && (reg_wdata[2] || ctrl_q[2]);

  wire [7:0] thresh  = ctrl_q[23:16];
  wire [7:0] dly     = ctrl_q[31:24];
  wire       restart = done_pulse && dly != 8'd0;
  wire       tick    = tmr_q != 8'd0 && pre_q == PRE_LAST;
  wire       dly_hit = tick && tmr_q == 8'd1 && !restart;
  wire       ioc_hit = done_pulse && cnt_q == 8'd1;
  wire [2:0] clr     = wr_stat ? reg_wdata[14:12] : 3'b000;

  always_comb begin
    cnt_d = cnt_q;
    if (dly_hit) cnt_d = thresh;
    if (done_pulse) cnt_d = ioc_hit ? thresh : cnt_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_INIT;
      cur_q       <= '0;
      tail_q      <= '0;
      halt_q      <= 1'b1;
      idle_q      <= 1'b0;
      flag_q      <= '0;
      cnt_q       <= 8'd1;
      tmr_q       <= '0;
      pre_q       <= '0;
      start_o     <= 1'b0;
      tail_kick_o <= 1'b0;
    end else begin
      start_o     <= 1'b0;
      tail_kick_o <= 1'b0;
      cnt_q       <= cnt_d;
      flag_q      <= (flag_q & ~clr) | {1'b0, dly_hit, ioc_hit};
      if (restart) begin
        tmr_q <= dly;
        pre_q <= '0;
      end else if (tmr_q != 8'd0) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) tmr_q <= tmr_q - 8'd1;
      end
      if (idle_set) idle_q <= 1'b1;
      if (rd_ctrl) ctrl_q[2] <= 1'b0;
      if (wr_cur) cur_q <= reg_wdata;
      if (wr_tail) begin
        tail_q      <= reg_wdata;
        idle_q      <= 1'b0;
        tail_kick_o <= 1'b1;
      end
      if (soft_rst) begin
        ctrl_q <= CTRL_INIT | 32'h4;
        halt_q <= 1'b1;
        idle_q <= 1'b0;
        flag_q <= '0;
        cnt_q  <= 8'd1;
        tmr_q  <= '0;
        pre_q  <= '0;
      end else if (wr_ctrl) begin
        ctrl_q <= reg_wdata | 32'h2;
        cnt_q  <= reg_wdata[23:16];
        if (reg_wdata[0]) begin
          halt_q  <= 1'b0;
          idle_q  <= 1'b0;
          start_o <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q & ~32'h4;
      A_STAT:  reg_rdata = {tmr_q, cnt_q, 1'b0, flag_q, 10'b0, idle_q, halt_q};
      A_CUR:   reg_rdata = cur_q;
      A_TAIL:  reg_rdata = tail_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq         = |(flag_q & ctrl_q[14:12]);
  assign run_o       = ctrl_q[0];
  assign cur_desc_o  = cur_q;
  assign tail_desc_o = tail_q;

  p_rst_clears_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> !ctrl_q[2]);

  p_no_start_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !start_o && halt_q);

  p_start_from_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(wr_ctrl && reg_wdata[0]));

  p_ioc_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ioc_hit && !wr_ctrl) |=> flag_q[0] && cnt_q == $past(thresh));

  p_timer_never_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q != 8'd0 && !done_pulse) |=> tmr_q <= $past(tmr_q));

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[12] && !ioc_hit) |=> !flag_q[0]);

  p_kick_from_tail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tail_kick_o |-> $past(wr_tail));

endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic done_pulse = 1'b0, idle_set = 1'b0;
  logic irq, start_o, tail_kick_o, run_o;
  logic [31:0] cur_desc_o, tail_desc_o;

  int checks = 0, fails = 0;
  string rd_tag = "";

  always #10 clk = ~clk;

  dma_chan_regs #(.ADDR_W(6), .TICK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_pulse(done_pulse), .idle_set(idle_set), .irq(irq),
    .start_o(start_o), .tail_kick_o(tail_kick_o), .run_o(run_o),
    .cur_desc_o(cur_desc_o), .tail_desc_o(tail_desc_o));

  logic [31:0] m_ctrl, m_cur, m_tail;
  logic m_halt, m_idle, m_start, m_kick;
  logic [2:0] m_flags;
  logic [7:0] m_cnt, m_tmr;
  int m_pre;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 32'h0001_0002; m_cur = 0; m_tail = 0;
      m_halt = 1; m_idle = 0; m_flags = 0; m_cnt = 1; m_tmr = 0; m_pre = 0;
      m_start = 0; m_kick = 0;
    end else begin
      logic [7:0] old_cnt, thr;
      logic expire, ticked;
      old_cnt = m_cnt; thr = m_ctrl[23:16];
      m_start = 0; m_kick = 0;
      ticked = m_tmr != 0 && m_pre == DIV - 1;
      expire = ticked && m_tmr == 1;
      if (reg_wr && reg_addr == 6'h04) m_flags = m_flags & ~reg_wdata[14:12];
      if (done_pulse && m_ctrl[31:24] != 0) begin
        m_tmr = m_ctrl[31:24]; m_pre = 0; expire = 0;
      end else if (m_tmr != 0) begin
        if (ticked) begin m_pre = 0; m_tmr = m_tmr - 1; end
        else m_pre = m_pre + 1;
      end
      if (expire) begin m_flags[1] = 1; m_cnt = thr; end
      if (done_pulse) begin
        if (old_cnt == 1) begin m_flags[0] = 1; m_cnt = thr; end
        else m_cnt = old_cnt - 1;
      end
      if (idle_set) m_idle = 1;
      if (reg_rd && !reg_wr && reg_addr == 6'h00) m_ctrl[2] = 0;
      if (reg_wr && reg_addr == 6'h08) m_cur = reg_wdata;
      if (reg_wr && reg_addr == 6'h10) begin m_tail = reg_wdata; m_idle = 0; m_kick = 1; end
      if (reg_wr && reg_addr == 6'h00) begin
        if (reg_wdata[2] || m_ctrl[2]) begin
          m_ctrl = 32'h0001_0006; m_halt = 1; m_idle = 0; m_flags = 0;
          m_cnt = 1; m_tmr = 0; m_pre = 0;
        end else begin
          m_ctrl = reg_wdata | 32'h2; m_cnt = reg_wdata[23:16];
          if (reg_wdata[0]) begin m_halt = 0; m_idle = 0; m_start = 1; end
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_ctrl & ~32'h4;
      6'h04: return {m_tmr, m_cnt, 1'b0, m_flags, 10'b0, m_idle, m_halt};
      6'h08: return m_cur;
      6'h10: return m_tail;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 irq", {31'b0, irq}, {31'b0, |(m_flags & m_ctrl[14:12])});
      chk("R4 start_o", {31'b0, start_o}, {31'b0, m_start});
      chk("R4 run_o", {31'b0, run_o}, {31'b0, m_ctrl[0]});
      chk("R10 tail_kick_o", {31'b0, tail_kick_o}, {31'b0, m_kick});
      chk("R10 tail_desc_o", tail_desc_o, m_tail);
      chk("R12 cur_desc_o", cur_desc_o, m_cur);
      if (reg_rd) chk(rd_tag, reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(posedge clk); #2;
    reg_rd = 1; reg_addr = a; rd_tag = tag;
    @(posedge clk); #2;
    reg_rd = 0;
  endtask

  task automatic done1();
    @(posedge clk); #2; done_pulse = 1;
    @(posedge clk); #2; done_pulse = 0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    gap(3); #2 rst_n = 1;
    rd(6'h00, "R1 control after reset");
    rd(6'h04, "R1 status after reset");
    wr(6'h00, 32'h0003_7001);
    rd(6'h04, "R4 run clears halted");
    rd(6'h00, "R2 tail mode bit forced");
    done1(); rd(6'h04, "R9 live count 2");
    done1(); rd(6'h04, "R5 no flag before threshold");
    done1(); rd(6'h04, "R5 flag at threshold and reload");
    wr(6'h04, 32'h0000_0003); rd(6'h04, "R7 low bits unaffected");
    wr(6'h04, 32'h0000_1000); rd(6'h04, "R7 completion flag cleared");
    wr(6'h00, 32'h0503_3001);
    done1(); rd(6'h04, "R6 timer loaded");
    gap(9); rd(6'h04, "R9 timer counting");
    gap(20); rd(6'h04, "R6 timer expired flag and reload");
    wr(6'h04, 32'h0000_2000); rd(6'h04, "R7 delay flag cleared");
    done1(); gap(3); done1(); rd(6'h04, "R6 restart by second completion");
    gap(30);
    wr(6'h00, 32'h0000_0001);
    done1(); rd(6'h04, "R5 zero threshold wraps");
    wr(6'h10, 32'h1234_5670); rd(6'h10, "R10 tail readback");
    @(posedge clk); #2 idle_set = 1; @(posedge clk); #2 idle_set = 0;
    rd(6'h04, "R11 idle set");
    wr(6'h10, 32'h0000_0040); rd(6'h04, "R10 tail clears idle");
    wr(6'h08, 32'hCAFE_0100); rd(6'h08, "R12 current descriptor");
    rd(6'h0C, "R12 unmapped reads zero");
    rd(6'h14, "R12 unmapped reads zero");
    wr(6'h00, 32'h0000_0000); rd(6'h00, "R2 bit 1 reads one");
    wr(6'h00, 32'h0002_3001); done1();
    wr(6'h00, 32'h0000_0004); rd(6'h04, "R3 soft reset status");
    wr(6'h00, 32'h0000_3001); rd(6'h04, "R3 write during reset stays halted");
    rd(6'h00, "R3 control read hides reset bit");
    wr(6'h00, 32'h0001_0001); rd(6'h04, "R4 run after reset released");
    gap(5);
    finish_run();
  end
endmodule